// File: doc/BRIEF.md
# Inter-Thread Synchronization Array

This block carries register values from producer instructions running on one core to consumer instructions running on another, without going through memory. Its storage is split into rows, one per dependence number, and every row holds a fixed number of slots. Each slot pairs exactly one produce with exactly one consume. Either of the two may arrive first. When the produce comes first, the slot holds the data until the consume collects it. When the consume comes first, the slot keeps the consumer's tag and forwards the data once the produce arrives.

The produce port gives a row, a slot, a data word and a producer tag. The consume port gives a row, a slot and a consumer tag. A completed pairing leaves the block on one writeback port as the data plus the consumer tag. At the same time the block tells both sides, each with its own tag, that the slot is free again. Slot allocation is done outside the block and is out of scope here, as are recovery from misspeculation and the saving and restoring of context.

Top module: `sync_array`

## Requirements
- R1: Reset empties every slot and holds the writeback, free-notification and error outputs low. A produce to any slot after reset is therefore stored and is not forwarded.
- R2: A produce to an empty slot stores its data and producer tag and gives no output. A later consume to that slot puts the stored data on the writeback port with the consume's tag, and empties the slot.
- R3: A consume to an empty slot parks its tag and gives no output. A later produce to that slot puts its data on the writeback port with the parked tag, and empties the slot.
- R4: Slots in different rows, and different slots in the same row, are fully independent of each other.
- R5: A produce and a consume to the same empty slot in the same cycle complete at once. Writeback carries the produce data and the consume tag, and the slot is left empty.
- R6: A produce to a slot that already holds data raises the error flag. The stored data and producer tag are kept.
- R7: A consume to a slot that already has a parked consumer raises the error flag. The first parked tag is kept.
- R8: When a forwarded produce and a consume hit complete in the same cycle, the forwarded result goes out on the next cycle. The consume-hit result follows one cycle after that.
- R9: When the one deferred entry is still occupied and a forward and a hit arrive together again, the new hit result is dropped and the error flag is raised. Its slot is still emptied.
- R10: A produce and a consume to the same slot in the same cycle, when that slot has a parked consumer, forward the data to the old tag. The new consume then parks.
- R11: A produce and a consume to the same slot in the same cycle, when that slot already holds data, raise the error flag for the produce. The consume receives the data that was stored earlier.
- R12: Each writeback is paired with a free notification to the producer side and one to the consumer side, in the same cycle. These carry the producer tag and the consumer tag of the pairing. Slot states are encoded as empty 2'b00, holding data 2'b01 and consumer parked 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prod_vld | input | 1 | Produce request valid |
| prod_row | input | 3 | Produce dependence row |
| prod_slot | input | 5 | Produce slot within the row |
| prod_data | input | 32 | Value produced |
| prod_tag | input | 8 | Producer instruction tag |
| cons_vld | input | 1 | Consume request valid |
| cons_row | input | 3 | Consume dependence row |
| cons_slot | input | 5 | Consume slot within the row |
| cons_tag | input | 8 | Consumer instruction tag |
| wb_vld | output | 1 | Writeback valid |
| wb_data | output | 32 | Writeback value |
| wb_tag | output | 8 | Consumer tag of the writeback |
| pfree_vld | output | 1 | Slot-free notice to the producer side |
| pfree_tag | output | 8 | Producer tag of the freed slot |
| cfree_vld | output | 1 | Slot-free notice to the consumer side |
| cfree_tag | output | 8 | Consumer tag of the freed slot |
| err | output | 1 | Protocol error seen in the previous access |

## Verification
Every access is sampled on a rising edge. Its writeback, free notices and error flag are registered, so they appear one cycle later. The one exception is a consume hit that loses the port to a forward: it is deferred and appears two cycles after its access. The bench drives each access at a falling edge and checks the outputs at the next falling edge. For the priority case it runs idle steps so that the deferred result is checked in the later cycle where it is due.

// File: rtl/sync_array.sv
module sync_array #(
  parameter int ROWS  = 8,
  parameter int SLOTS = 32,
  parameter int DW    = 32,
  parameter int TW    = 8,
  localparam int RW   = $clog2(ROWS),
  localparam int SW   = $clog2(SLOTS),
  localparam int N    = ROWS * SLOTS,
  localparam int IW   = RW + SW,
  localparam int RECW = DW + 2 * TW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prod_vld,
  input  logic [RW-1:0] prod_row,
  input  logic [SW-1:0] prod_slot,
  input  logic [DW-1:0] prod_data,
  input  logic [TW-1:0] prod_tag,
  input  logic          cons_vld,
  input  logic [RW-1:0] cons_row,
  input  logic [SW-1:0] cons_slot,
  input  logic [TW-1:0] cons_tag,
  output logic          wb_vld,
  output logic [DW-1:0] wb_data,
  output logic [TW-1:0] wb_tag,
  output logic          pfree_vld,
  output logic [TW-1:0] pfree_tag,
  output logic          cfree_vld,
  output logic [TW-1:0] cfree_tag,
  output logic          err
);
  localparam logic [1:0] S_EMPTY = 2'b00;
  localparam logic [1:0] S_FULL  = 2'b01;
  localparam logic [1:0] S_WAIT  = 2'b10;

  logic [1:0]    st  [N];
  logic [DW-1:0] dat [N];
  logic [TW-1:0] ptg [N];
  logic [TW-1:0] ctg [N];

  logic [IW-1:0]   pi, ci;
  logic [1:0]      cur_p, cur_c, mid, c_st;
  logic            same, p_fill, p_fwd, p_err, c_hit, c_park, c_err, byp, ovf;
  logic [RECW-1:0] fwd_rec, hit_rec, out_q, pend_q;
  logic            out_v, pend_v, err_q;

  assign pi     = {prod_row, prod_slot};
  assign ci     = {cons_row, cons_slot};
  assign cur_p  = st[pi];
  assign cur_c  = st[ci];
  assign same   = prod_vld && cons_vld && (pi == ci);
  assign p_fill = prod_vld && (cur_p == S_EMPTY);
  assign p_fwd  = prod_vld && (cur_p == S_WAIT);
  assign p_err  = prod_vld && (cur_p == S_FULL);
  assign mid    = p_fill ? S_FULL : (p_fwd ? S_EMPTY : cur_p);
  assign c_st   = same ? mid : cur_c;
  assign c_hit  = cons_vld && (c_st == S_FULL);
  assign c_park = cons_vld && (c_st == S_EMPTY);
  assign c_err  = cons_vld && (c_st == S_WAIT);
  assign byp    = same && p_fill;
  assign ovf    = p_fwd && c_hit && pend_v;

  assign fwd_rec = {prod_data, ctg[pi], prod_tag};
  assign hit_rec = {byp ? prod_data : dat[ci], cons_tag, byp ? prod_tag : ptg[ci]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) st[i] <= S_EMPTY;
    end else begin
      if (p_fill)      st[pi] <= S_FULL;
      else if (p_fwd)  st[pi] <= S_EMPTY;
      if (c_hit)       st[ci] <= S_EMPTY;
      else if (c_park) st[ci] <= S_WAIT;
    end
  end

  always_ff @(posedge clk) begin
    if (p_fill) begin
      dat[pi] <= prod_data;
      ptg[pi] <= prod_tag;
    end
    if (c_park) ctg[ci] <= cons_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_v  <= 1'b0;
      out_q  <= '0;
      pend_v <= 1'b0;
      pend_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= p_err || c_err || ovf;
      if (p_fwd) begin
        out_v <= 1'b1;
        out_q <= fwd_rec;
        if (c_hit && !pend_v) begin
          pend_v <= 1'b1;
          pend_q <= hit_rec;
        end
      end else if (pend_v) begin
        out_v  <= 1'b1;
        out_q  <= pend_q;
        pend_v <= c_hit;
        if (c_hit) pend_q <= hit_rec;
      end else begin
        out_v <= c_hit;
        if (c_hit) out_q <= hit_rec;
      end
    end
  end

  assign wb_vld    = out_v;
  assign wb_data   = out_q[RECW-1 -: DW];
  assign wb_tag    = out_q[2*TW-1 -: TW];
  assign cfree_vld = out_v;
  assign cfree_tag = out_q[2*TW-1 -: TW];
  assign pfree_vld = out_v;
  assign pfree_tag = out_q[TW-1:0];
  assign err       = err_q;
endmodule

// File: rtl/sync_array_chk.sv
module sync_array_chk (
  input logic clk,
  input logic rst_n,
  input logic prod_vld,
  input logic cons_vld,
  input logic wb_vld,
  input logic err
);
  AST_RST_QUIET: assert property (@(posedge clk) !rst_n |=> (!wb_vld && !err)); // R1
  AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(prod_vld || cons_vld)); // R6
  AST_WB_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_vld && !$past(wb_vld)) |-> $past(prod_vld || cons_vld)); // R3
  AST_IDLE_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!prod_vld && !cons_vld) && $past(!prod_vld && !cons_vld, 2) && $past(rst_n, 2))
    |-> !wb_vld); // R8
endmodule

bind sync_array sync_array_chk u_chk (
  .clk(clk), .rst_n(rst_n), .prod_vld(prod_vld), .cons_vld(cons_vld),
  .wb_vld(wb_vld), .err(err)
);

// File: tb/sync_array_tb.sv
module sync_array_tb;
  typedef struct packed {
    logic        pv; logic [2:0] pr; logic [4:0] ps; logic [31:0] pd; logic [7:0] pt;
    logic        cv; logic [2:0] cr; logic [4:0] cs; logic [7:0] ct;
    logic        ev; logic [31:0] ed; logic [7:0] ect; logic [7:0] ept; logic ee;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 45;
  localparam vec_t VEC [NV] = '{
    '{1,3'd0,5'd0,32'hA1,8'h11, 0,3'd0,5'd0,8'h00, 0,32'h0,8'h00,8'h00,0, 4'd2},  // R2
    '{0,3'd0,5'd0,32'h0,8'h00,  1,3'd0,5'd0,8'h21, 1,32'hA1,8'h21,8'h11,0, 4'd2},
    '{0,3'd0,5'd0,32'h0,8'h00,  1,3'd1,5'd3,8'h22, 0,32'h0,8'h00,8'h00,0, 4'd3},  // R3
    '{1,3'd1,5'd3,32'hB2,8'h12, 0,3'd0,5'd0,8'h00, 1,32'hB2,8'h22,8'h12,0, 4'd3},
    '{1,3'd2,5'd5,32'hC3,8'h13, 0,3'd0,5'd0,8'h00, 0,32'h0,8'h00,8'h00,0, 4'd4},  // R4
    '{1,3'd2,5'd6,32'hC4,8'h14, 0,3'd0,5'd0,8'h00, 0,32'h0,8'h00,8'h00,0, 4'd4},
    '{1,3'd3,5'd5,32'hC5,8'h15, 0,3'd0,5'd0,8'h00, 0,32'h0,8'h00,8'h00,0, 4'd4},
    '{0,3'd0,5'd0,32'h0,8'h00,  1,3'd2,5'd6,8'h23, 1,32'hC4,8'h23,8'h14,0, 4'd4},
    '{0,3'd0,5'd0,32'h0,8'h00,  1,3'd3,5'd5,8'h24, 1,32'hC5,8'h24,8'h15,0, 4'd4},
    '{0,3'd0,5'd0,32'h0,8'h00,  1,3'd2,5'd5,8'h25, 1,32'hC3,8'h25,8'h13,0, 4'd4},
    '{1,3'd4,5'd0,32'hD1,8'h16, 1,3'd4,5'd0,8'h26, 1,32'hD1,8'h26,8'h16,0, 4'd5},  // R5
    '{0,3'd0,5'd0,32'h0,8'h00,  1,3'd4,5'd0,8'h27, 0,32'h0,8'h00,8'h00,0, 4'd5},
    '{1,3'd4,5'd0,32'hD2,8'h17, 0,3'd0,5'd0,8'h00, 1,32'hD2,8'h27,8'h17,0, 4'd5},
    '{1,3'd5,5'd1,32'hE1,8'h18, 0,3'd0,5'd0,8'h00, 0,32'h0,8'h00,8'h00,0, 4'd6},  // R6
    '{1,3'd5,5'd1,32'hE2,8'h19, 0,3'd0,5'd0,8'h00, 0,32'h0,8'h00,8'h00,1, 4'd6},
    '{0,3'd0,5'd0,32'h0,8'h00,  1,3'd5,5'd1,8'h28, 1,32'hE1,8'h28,8'h18,0, 4'd6},
    '{0,3'd0,5'd0,32'h0,8'h00,  1,3'd6,5'd2,8'h29, 0,32'h0,8'h00,8'h00,0, 4'd7},  // R7
    '{0,3'd0,5'd0,32'h0,8'h00,  1,3'd6,5'd2,8'h2A, 0,32'h0,8'h00,8'h00,1, 4'd7},
    '{1,3'd6,5'd2,32'hF1,8'h1A, 0,3'd0,5'd0,8'h00, 1,32'hF1,8'h29,8'h1A,0, 4'd7},
    '{0,3'd0,5'd0,32'h0,8'h00,  1,3'd7,5'd0,8'h2B, 0,32'h0,8'h00,8'h00,0, 4'd8},  // R8
    '{1,3'd7,5'd1,32'h61,8'h1B, 0,3'd0,5'd0,8'h00, 0,32'h0,8'h00,8'h00,0, 4'd8},
    '{1,3'd7,5'd0,32'h60,8'h1C, 1,3'd7,5'd1,8'h2C, 1,32'h60,8'h2B,8'h1C,0, 4'd8},
    '{0,3'd0,5'd0,32'h0,8'h00,  0,3'd0,5'd0,8'h00, 1,32'h61,8'h2C,8'h1B,0, 4'd8},
    '{0,3'd0,5'd0,32'h0,8'h00,  0,3'd0,5'd0,8'h00, 0,32'h0,8'h00,8'h00,0, 4'd8},
    '{0,3'd0,5'd0,32'h0,8'h00,  1,3'd0,5'd7,8'h2D, 0,32'h0,8'h00,8'h00,0, 4'd10}, // R10
    '{1,3'd0,5'd7,32'h71,8'h1D, 1,3'd0,5'd7,8'h2E, 1,32'h71,8'h2D,8'h1D,0, 4'd10},
    '{1,3'd0,5'd7,32'h72,8'h1E, 0,3'd0,5'd0,8'h00, 1,32'h72,8'h2E,8'h1E,0, 4'd10},
    '{1,3'd1,5'd7,32'h81,8'h1F, 0,3'd0,5'd0,8'h00, 0,32'h0,8'h00,8'h00,0, 4'd11}, // R11
    '{1,3'd1,5'd7,32'h82,8'h20, 1,3'd1,5'd7,8'h2F, 1,32'h81,8'h2F,8'h1F,1, 4'd11},
    '{0,3'd0,5'd0,32'h0,8'h00,  1,3'd1,5'd7,8'h30, 0,32'h0,8'h00,8'h00,0, 4'd11},
    '{0,3'd0,5'd0,32'h0,8'h00,  1,3'd2,5'd0,8'h31, 0,32'h0,8'h00,8'h00,0, 4'd9},  // R9
    '{0,3'd0,5'd0,32'h0,8'h00,  1,3'd2,5'd1,8'h32, 0,32'h0,8'h00,8'h00,0, 4'd9},
    '{1,3'd3,5'd0,32'h90,8'h21, 0,3'd0,5'd0,8'h00, 0,32'h0,8'h00,8'h00,0, 4'd9},
    '{1,3'd3,5'd1,32'h91,8'h22, 0,3'd0,5'd0,8'h00, 0,32'h0,8'h00,8'h00,0, 4'd9},
    '{1,3'd2,5'd0,32'h50,8'h23, 1,3'd3,5'd0,8'h33, 1,32'h50,8'h31,8'h23,0, 4'd9},
    '{1,3'd2,5'd1,32'h51,8'h24, 1,3'd3,5'd1,8'h34, 1,32'h51,8'h32,8'h24,1, 4'd9},
    '{0,3'd0,5'd0,32'h0,8'h00,  0,3'd0,5'd0,8'h00, 1,32'h90,8'h33,8'h21,0, 4'd9},
    '{0,3'd0,5'd0,32'h0,8'h00,  0,3'd0,5'd0,8'h00, 0,32'h0,8'h00,8'h00,0, 4'd9},
    '{0,3'd0,5'd0,32'h0,8'h00,  1,3'd3,5'd1,8'h35, 0,32'h0,8'h00,8'h00,0, 4'd9},
    '{1,3'd4,5'd2,32'hA0,8'h25, 0,3'd0,5'd0,8'h00, 0,32'h0,8'h00,8'h00,0, 4'd12}, // R12
    '{0,3'd0,5'd0,32'h0,8'h00,  1,3'd4,5'd3,8'h36, 0,32'h0,8'h00,8'h00,0, 4'd12},
    '{1,3'd4,5'd4,32'hA4,8'h26, 0,3'd0,5'd0,8'h00, 0,32'h0,8'h00,8'h00,0, 4'd12},
    '{1,3'd4,5'd3,32'hA3,8'h27, 1,3'd4,5'd2,8'h37, 1,32'hA3,8'h36,8'h27,0, 4'd12},
    '{0,3'd0,5'd0,32'h0,8'h00,  1,3'd4,5'd4,8'h38, 1,32'hA0,8'h37,8'h25,0, 4'd12},
    '{0,3'd0,5'd0,32'h0,8'h00,  0,3'd0,5'd0,8'h00, 1,32'hA4,8'h38,8'h26,0, 4'd12}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic prod_vld, cons_vld;
  logic [2:0] prod_row, cons_row;
  logic [4:0] prod_slot, cons_slot;
  logic [31:0] prod_data, wb_data;
  logic [7:0] prod_tag, cons_tag, wb_tag, pfree_tag, cfree_tag;
  logic wb_vld, pfree_vld, cfree_vld, err;
  int checks = 0, bad = 0;

  always #5 clk = ~clk;

  sync_array u_dut (
    .clk(clk), .rst_n(rst_n),
    .prod_vld(prod_vld), .prod_row(prod_row), .prod_slot(prod_slot),
    .prod_data(prod_data), .prod_tag(prod_tag),
    .cons_vld(cons_vld), .cons_row(cons_row), .cons_slot(cons_slot), .cons_tag(cons_tag),
    .wb_vld(wb_vld), .wb_data(wb_data), .wb_tag(wb_tag),
    .pfree_vld(pfree_vld), .pfree_tag(pfree_tag),
    .cfree_vld(cfree_vld), .cfree_tag(cfree_tag), .err(err)
  );

  task automatic drive(input vec_t x);
    prod_vld = x.pv; prod_row = x.pr; prod_slot = x.ps; prod_data = x.pd; prod_tag = x.pt;
    cons_vld = x.cv; cons_row = x.cr; cons_slot = x.cs; cons_tag = x.ct;
  endtask

  task automatic chk(input vec_t x);
    checks++;
    if (wb_vld !== x.ev || err !== x.ee || pfree_vld !== x.ev || cfree_vld !== x.ev ||
        (x.ev && (wb_data !== x.ed || wb_tag !== x.ect || pfree_tag !== x.ept || cfree_tag !== x.ect))) begin
      bad++;
      $display("FAIL R%0d: actual vld=%b data=%h ctag=%h ptag=%h err=%b expected vld=%b data=%h ctag=%h ptag=%h err=%b",
               x.rq, wb_vld, wb_data, wb_tag, pfree_tag, err, x.ev, x.ed, x.ect, x.ept, x.ee);
    end
  endtask

  task automatic step(input vec_t x);
    drive(x);
    @(negedge clk);
    chk(x);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; bad++;
    $display("FAIL R1: watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    vec_t d;
    d = '0;
    drive(d);
    repeat (3) @(negedge clk);
    d.rq = 4'd1;
    chk(d);                                   // R1 outputs low in reset
    rst_n = 1'b1;
    @(negedge clk);
    chk(d);                                   // R1 quiet after release
    for (int i = 0; i < NV; i++) step(VEC[i]);
    d = '0; d.cv = 1; d.cr = 3'd5; d.cs = 5'd5; d.ct = 8'h40; d.rq = 4'd1;
    step(d);                                  // R1 park, then reset clears it
    rst_n = 1'b0;
    d = '0; drive(d);
    @(negedge clk);
    rst_n = 1'b1;
    d = '0; d.pv = 1; d.pr = 3'd5; d.ps = 5'd5; d.pd = 32'h99; d.pt = 8'h41; d.rq = 4'd1;
    step(d);                                  // R1 no forward to cleared tag
    d = '0; d.cv = 1; d.cr = 3'd5; d.cs = 5'd5; d.ct = 8'h42;
    d.ev = 1; d.ed = 32'h99; d.ect = 8'h42; d.ept = 8'h41; d.rq = 4'd1;
    step(d);                                  // R1 stored after reset
    d = '0; d.rq = 4'd1;
    step(d);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule